// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block manages sixteen general-purpose pins arranged as two banks of eight, configured through a byte-wide register bus. Each pin has two configuration bytes. The first sets direction, open-drain versus push-pull drive, pull enable, a pull-select code and the output level. The second selects which edge is detected and reads back the synchronised pin level.

Detected edges set per-bank pending flags. Software clears a flag by writing a 1 back to its bit. Per-bank mask bytes gate which pending flags reach a single level-sensitive interrupt output. A second pair of per-bank mask bytes is stored but has no effect. A standalone panel byte is also stored, and its lowest bit drives a dedicated output.

The register bus has no handshake. A write takes effect on the clock edge where `wr_en_i` is high. Read data is a combinational function of `addr_i` and the register state.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every pin is an input with its outputs disabled and edge detection off. All pending bits read 0, all four mask bytes read 0xFF, the panel byte reads 0x00 and `irq_o` is low.
- R2: The output byte of pin n sits at 0x2B+n for n<8 and at 0x3B+(n-8) for n>=8. Bits 5:0 read back as written and bits 7:6 read 0.
- R3: In the output byte, bit 0 is the level on `pin_o`, bit 3 is `pull_en_o`, bits 2:1 are the pull code on `pull_sel_o[2n+1:2n]`, bit 4 selects open-drain and bit 5 selects output. `pin_oe_o` is high when bit 5 is 1, except in open-drain mode while bit 0 is 1.
- R4: The input byte of pin n sits at 0x33+n for n<8 and at 0x43+(n-8) for n>=8. Bit 0 shows `pin_i` as it was two clock edges earlier. Bits 2:1 read back the edge mode and bits 7:3 read 0.
- R5: Edge mode 0 detects nothing, 1 detects falling edges, 2 detects rising edges and 3 detects both. A detected edge sets the pin's pending bit on the third clock edge after `pin_i` changes.
- R6: The pending bytes are at 0x0B (bank 0) and 0x0C (bank 1), with bit k belonging to in-bank pin k. Writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R7: When a new edge and a clear of the same pending bit fall on the same clock edge, the bit stays set.
- R8: The mask bytes are at 0x19 (bank 0) and 0x1A (bank 1), and a 1 masks that pin. A masked pin still sets its pending bit.
- R9: `irq_o` is high exactly while some pending bit has its mask bit at 0.
- R10: The bytes at 0x1B and 0x1C are read/write storage with no effect on `irq_o`.
- R11: The byte at 0x52 is read/write storage, and `panel_o` follows its bit 0.
- R12: Reads of any other address return 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pin_i | input | 16 | Pad input levels |
| pin_o | output | 16 | Pad output levels |
| pin_oe_o | output | 16 | Pad output enables |
| pull_en_o | output | 16 | Pull resistor enables |
| pull_sel_o | output | 32 | Two-bit pull code per pin |
| panel_o | output | 1 | Panel control output |
| irq_o | output | 1 | Aggregated interrupt level |

## Verification
The assertions assume that `pin_i` is low while reset is held, so that no spurious edge is seen on release. They also assume that bus inputs change only away from the rising clock edge. The bench drives all pins low through reset and changes every input on the falling clock edge.

A pin is toggled again only after its pending result has settled. The one exception is the deliberately aligned edge-and-clear case, which places the clear write on the exact edge where the new edge is detected.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam logic [7:0] PEND_BASE   = 8'h0B;
  localparam logic [7:0] MASK_BASE   = 8'h19;
  localparam logic [7:0] AUX_BASE    = 8'h1B;
  localparam logic [7:0] OUT_BASE    = 8'h2B;
  localparam logic [7:0] IN_BASE     = 8'h33;
  localparam logic [7:0] BANK_STRIDE = 8'h10;
  localparam logic [7:0] PANEL_ADDR  = 8'h52;

  localparam int unsigned CFG_BITS = 6;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  function automatic logic [7:0] out_addr(int unsigned bank, int unsigned idx);
    return 8'(OUT_BASE + bank * BANK_STRIDE + idx);
  endfunction

  function automatic logic [7:0] in_addr(int unsigned bank, int unsigned idx);
    return 8'(IN_BASE + bank * BANK_STRIDE + idx);
  endfunction

  function automatic logic [7:0] pend_addr(int unsigned bank);
    return 8'(PEND_BASE + bank);
  endfunction

  function automatic logic [7:0] mask_addr(int unsigned bank);
    return 8'(MASK_BASE + bank);
  endfunction

  function automatic logic [7:0] aux_addr(int unsigned bank);
    return 8'(AUX_BASE + bank);
  endfunction

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pad_i,
  input  logic                out_we_i,
  input  logic [CFG_BITS-1:0] out_wdata_i,
  input  logic                in_we_i,
  input  logic [1:0]          mode_wdata_i,
  output logic [7:0]          out_cfg_o,
  output logic [7:0]          in_cfg_o,
  output logic                edge_o,
  output logic                pad_o,
  output logic                pad_oe_o,
  output logic                pull_en_o,
  output logic [1:0]          pull_sel_o
);

  localparam int unsigned LVL_BIT  = 0;
  localparam int unsigned PEN_BIT  = 3;
  localparam int unsigned OD_BIT   = 4;
  localparam int unsigned DIR_BIT  = 5;

  logic [CFG_BITS-1:0]    cfg_q;
  edge_mode_e             mode_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level;
  logic                   rise, fall;

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mode_q <= EDGE_OFF;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      if (out_we_i) cfg_q <= out_wdata_i;
      if (in_we_i)  mode_q <= edge_mode_e'(mode_wdata_i);
      sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
      prev_q <= level;
    end
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

  always_comb begin
    unique case (mode_q)
      EDGE_FALL: edge_o = fall;
      EDGE_RISE: edge_o = rise;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end

  // open-drain: only a low level is actively driven
  assign pad_o      = cfg_q[LVL_BIT];
  assign pad_oe_o   = cfg_q[DIR_BIT] & (~cfg_q[OD_BIT] | ~cfg_q[LVL_BIT]);
  assign pull_en_o  = cfg_q[PEN_BIT];
  assign pull_sel_o = cfg_q[2:1];

  assign out_cfg_o = {2'b00, cfg_q};
  assign in_cfg_o  = {5'b00000, mode_q, level};

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] edge_i,
  input  logic             pend_we_i,
  input  logic             mask_we_i,
  input  logic             aux_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] aux_o
);

  logic [WIDTH-1:0] ack;

  assign ack = pend_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      mask_o <= '1;
      aux_o  <= '1;
    end else begin
      // a fresh edge outranks a simultaneous clear
      pend_o <= (pend_o & ~ack) | edge_i;
      if (mask_we_i) mask_o <= wdata_i;
      if (aux_we_i)  aux_o  <= wdata_i;
    end
  end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned PINS_PER_BANK = 8,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [7:0]                             addr_i,
  input  logic                                   wr_en_i,
  input  logic [7:0]                             wdata_i,
  output logic [7:0]                             rdata_o,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0]     pin_i,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]     pin_o,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]     pin_oe_o,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]     pull_en_o,
  output logic [2*NUM_BANKS*PINS_PER_BANK-1:0]   pull_sel_o,
  output logic                                   panel_o,
  output logic                                   irq_o
);

  localparam int unsigned NUM_PINS = NUM_BANKS * PINS_PER_BANK;

  logic [7:0]          out_cfg [NUM_PINS];
  logic [7:0]          in_cfg  [NUM_PINS];
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] pend_vec, mask_vec, aux_vec;
  logic [7:0]          panel_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int unsigned BANK = i / PINS_PER_BANK;
    localparam int unsigned IDX  = i % PINS_PER_BANK;
    gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pad_i        (pin_i[i]),
      .out_we_i     (wr_en_i && (addr_i == out_addr(BANK, IDX))),
      .out_wdata_i  (wdata_i[CFG_BITS-1:0]),
      .in_we_i      (wr_en_i && (addr_i == in_addr(BANK, IDX))),
      .mode_wdata_i (wdata_i[2:1]),
      .out_cfg_o    (out_cfg[i]),
      .in_cfg_o     (in_cfg[i]),
      .edge_o       (edge_hit[i]),
      .pad_o        (pin_o[i]),
      .pad_oe_o     (pin_oe_o[i]),
      .pull_en_o    (pull_en_o[i]),
      .pull_sel_o   (pull_sel_o[2*i +: 2])
    );
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_irq_bank #(.WIDTH(PINS_PER_BANK)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .edge_i    (edge_hit[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .pend_we_i (wr_en_i && (addr_i == pend_addr(b))),
      .mask_we_i (wr_en_i && (addr_i == mask_addr(b))),
      .aux_we_i  (wr_en_i && (addr_i == aux_addr(b))),
      .wdata_i   (wdata_i[PINS_PER_BANK-1:0]),
      .pend_o    (pend_vec[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .mask_o    (mask_vec[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .aux_o     (aux_vec[b*PINS_PER_BANK +: PINS_PER_BANK])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) panel_q <= 8'h00;
    else if (wr_en_i && (addr_i == PANEL_ADDR)) panel_q <= wdata_i;
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == pend_addr(b)) rdata_o = 8'(pend_vec[b*PINS_PER_BANK +: PINS_PER_BANK]);
      if (addr_i == mask_addr(b)) rdata_o = 8'(mask_vec[b*PINS_PER_BANK +: PINS_PER_BANK]);
      if (addr_i == aux_addr(b))  rdata_o = 8'(aux_vec[b*PINS_PER_BANK +: PINS_PER_BANK]);
    end
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr_i == out_addr(i / PINS_PER_BANK, i % PINS_PER_BANK)) rdata_o = out_cfg[i];
      if (addr_i == in_addr(i / PINS_PER_BANK, i % PINS_PER_BANK))  rdata_o = in_cfg[i];
    end
    if (addr_i == PANEL_ADDR) rdata_o = panel_q;
  end

  assign panel_o = panel_q[0];
  assign irq_o   = |(pend_vec & ~mask_vec);

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int unsigned NUM_PINS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [7:0]          addr_i,
  input logic                wr_en_i,
  input logic [7:0]          wdata_i,
  input logic [7:0]          rdata_o,
  input logic                irq_o,
  input logic                panel_o,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] edge_hit
);

  logic mapped, pend_wr;

  always_comb begin
    mapped = (addr_i >= 8'h0B && addr_i <= 8'h0C) ||
             (addr_i >= 8'h19 && addr_i <= 8'h1C) ||
             (addr_i >= 8'h2B && addr_i <= 8'h4A) ||
             (addr_i == 8'h52);
    pend_wr = wr_en_i && (addr_i == 8'h0B || addr_i == 8'h0C);
  end

  assert_unmapped_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (rdata_o == 8'h00));

  assert_pend_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_wr && (edge_hit == '0)) |=> $stable(pend_vec));

  assert_edge_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_hit) |=> ((pend_vec & $past(edge_hit)) == $past(edge_hit)));

  assert_irq_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|pend_vec));

  assert_panel_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 8'h52) |=> (panel_o == $past(wdata_i[0])));

endmodule

bind gpio_ctrl gpio_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .panel_o  (panel_o),
  .pend_vec (pend_vec),
  .edge_hit (edge_hit)
);

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic [15:0] pin_i = 16'h0000;
  logic [15:0] pin_o, pin_oe_o, pull_en_o;
  logic [31:0] pull_sel_o;
  logic        panel_o, irq_o;

  gpio_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .pull_en_o(pull_en_o), .pull_sel_o(pull_sel_o),
    .panel_o(panel_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  localparam int K_RD = 0, K_IRQ = 1, K_PIN = 2, K_OE = 3, K_PEN = 4, K_PSEL = 5, K_PANEL = 6;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t       it;
      logic [31:0] got;
      @(mon_ev);
      #1;
      it = q.pop_front();
      case (it.kind)
        K_RD:    got = 32'(rdata_o);
        K_IRQ:   got = 32'(irq_o);
        K_PIN:   got = 32'(pin_o);
        K_OE:    got = 32'(pin_oe_o);
        K_PEN:   got = 32'(pull_en_o);
        K_PSEL:  got = pull_sel_o;
        default: got = 32'(panel_o);
      endcase
      vectors++;
      if (got !== it.exp) begin
        miscompares++;
        $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, got, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    #1;
    q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic chk_rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk_i);
    addr_i = a;
    push(K_RD, 32'(exp), tag);
  endtask

  task automatic chk_port(int kind, logic [31:0] exp, string tag);
    @(negedge clk_i);
    push(kind, exp, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i  = a;
    wdata_i = d;
    wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_pin(int n, logic v);
    @(negedge clk_i);
    pin_i[n] = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk_rd(8'h2B, 8'h00, "R1 out cfg");
    chk_rd(8'h43, 8'h00, "R1 in cfg");
    chk_rd(8'h0B, 8'h00, "R1 pending");
    chk_rd(8'h19, 8'hFF, "R1 mask0");
    chk_rd(8'h1A, 8'hFF, "R1 mask1");
    chk_rd(8'h1B, 8'hFF, "R1 aux0");
    chk_rd(8'h52, 8'h00, "R1 panel");
    chk_port(K_OE, 32'h0, "R1 oe");
    chk_port(K_IRQ, 32'h0, "R1 irq");

    // R2 addressing and readback
    wr(8'h2E, 8'hFF);                      // pin 3
    wr(8'h40, 8'h2A);                      // pin 13
    chk_rd(8'h2E, 8'h3F, "R2 pin3 out");
    chk_rd(8'h40, 8'h2A, "R2 pin13 out");

    // R3 pad controls
    chk_port(K_OE, 32'h2000, "R3 oe od-high");
    chk_port(K_PIN, 32'h0008, "R3 level");
    chk_port(K_PEN, 32'h2008, "R3 pull en");
    chk_port(K_PSEL, 32'h040000C0, "R3 pull sel");
    wr(8'h2E, 8'h30);
    chk_port(K_OE, 32'h2008, "R3 oe od-low");
    chk_port(K_PIN, 32'h0000, "R3 level low");
    wr(8'h2E, 8'h01);
    chk_port(K_OE, 32'h2000, "R3 oe input");
    chk_port(K_PIN, 32'h0008, "R3 level input");

    // R4 input readback, R5 both-edge timing, R8 masked pending
    set_pin(9, 1'b1);
    settle();
    chk_rd(8'h44, 8'h01, "R4 level high");
    wr(8'h44, 8'hFF);
    chk_rd(8'h44, 8'h07, "R4 mode readback");
    chk_rd(8'h0C, 8'h00, "R5 no edge on mode set");
    set_pin(9, 1'b0);
    chk_rd(8'h44, 8'h07, "R4 level after one edge");
    chk_rd(8'h44, 8'h06, "R4 level after two edges");
    chk_rd(8'h0C, 8'h02, "R5 both fall pending");
    chk_port(K_IRQ, 32'h0, "R8 masked irq");

    // R10 aux mask has no effect
    wr(8'h1C, 8'h00);
    chk_rd(8'h1C, 8'h00, "R10 aux readback");
    chk_port(K_IRQ, 32'h0, "R10 aux no irq");

    // R9 unmask
    wr(8'h1A, 8'hFD);
    chk_rd(8'h1A, 8'hFD, "R8 mask readback");
    chk_port(K_IRQ, 32'h1, "R9 irq on unmask");

    // R6 acknowledge
    wr(8'h0C, 8'h00);
    chk_rd(8'h0C, 8'h02, "R6 zero write keeps");
    wr(8'h0C, 8'h02);
    chk_rd(8'h0C, 8'h00, "R6 one write clears");
    chk_port(K_IRQ, 32'h0, "R9 irq drops");

    // R5 modes on pin 2
    wr(8'h19, 8'h00);
    wr(8'h35, 8'h04);
    set_pin(2, 1'b1); settle();
    chk_rd(8'h0B, 8'h04, "R5 rise mode rise");
    chk_port(K_IRQ, 32'h1, "R9 irq bank0");
    wr(8'h0B, 8'h04);
    set_pin(2, 1'b0); settle();
    chk_rd(8'h0B, 8'h00, "R5 rise mode fall");
    wr(8'h35, 8'h02);
    set_pin(2, 1'b1); settle();
    chk_rd(8'h0B, 8'h00, "R5 fall mode rise");
    set_pin(2, 1'b0); settle();
    chk_rd(8'h0B, 8'h04, "R5 fall mode fall");
    wr(8'h0B, 8'h04);
    wr(8'h35, 8'h00);
    set_pin(2, 1'b1); settle();
    set_pin(2, 1'b0); settle();
    chk_rd(8'h0B, 8'h00, "R5 off mode");

    // R7 edge coinciding with clear
    wr(8'h37, 8'h06);
    set_pin(4, 1'b1); settle();
    chk_rd(8'h0B, 8'h10, "R7 setup pending");
    set_pin(4, 1'b0);
    @(negedge clk_i);
    wr(8'h0B, 8'h10);
    chk_rd(8'h0B, 8'h10, "R7 edge wins");
    wr(8'h0B, 8'h10);
    chk_rd(8'h0B, 8'h00, "R7 later clear");

    // R11 panel
    wr(8'h52, 8'hA5);
    chk_rd(8'h52, 8'hA5, "R11 panel readback");
    chk_port(K_PANEL, 32'h1, "R11 panel high");
    wr(8'h52, 8'h04);
    chk_port(K_PANEL, 32'h0, "R11 panel low");

    // R12 unmapped
    wr(8'h4B, 8'hFF);
    chk_rd(8'h4B, 8'h00, "R12 unmapped 4B");
    wr(8'h0D, 8'hFF);
    chk_rd(8'h0D, 8'h00, "R12 unmapped 0D");
    chk_rd(8'h18, 8'h00, "R12 unmapped 18");
    chk_rd(8'h52, 8'h04, "R12 panel untouched");
    chk_rd(8'h0C, 8'h00, "R12 pending untouched");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule